// File: doc/BRIEF.md
# Diagnostic Register Bank with Split Access

This block is a small memory-mapped register bank that lets host software check its register access path and the interrupt path of a device. The host reaches it through a plain bus of address, write enable, access size (4 or 8 bytes), 64-bit write data and 64-bit read data. The read data is combinational from the address. Writes take effect at the clock edge on which the write enable is high.

There are two scratch registers, one 32 bits and one 64 bits wide. Each reads back as twice the value last written, so a stuck or swapped data bit shows up at once. The 64-bit register can be written in one 8-byte access. It can also be written as two 4-byte accesses, lower half first: the lower half waits in a staging register, and the full value changes only when the upper half arrives.

Writing a vector number to the interrupt-test register sets one bit in a pending vector of `NUM_VEC` bits and gives a one-cycle strobe that carries that number. A write of 1 to bit 0 of the control register clears the bank's own state in one cycle. The address window is `WIN_BYTES` wide, and every offset that no register uses reads as zero.

Top module: `diag_regbank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every register reads zero, irq_pend is all zero and irq_strobe is low.
- R2: A write to offset 0x0010 stores bus_wdata[31:0]. A read there returns twice that value modulo 2^32 in bus_rdata[31:0], with bus_rdata[63:32] zero.
- R3: An 8-byte write (bus_dw=1) to offset 0x0018 replaces the whole 64-bit register. An 8-byte read at 0x0018 returns twice the stored value modulo 2^64.
- R4: A 4-byte write (bus_dw=0) to 0x0018 only loads the staging register, and the 64-bit value read back does not change. A following 4-byte write to 0x001C makes the stored value {bus_wdata[31:0], staged lower half}.
- R5: A 4-byte write to 0x001C with no lower-half write before it is still accepted. It combines with whatever the staging register holds, which is zero after reset.
- R6: A 4-byte read at 0x0018 returns bits 31:0 of the doubled 64-bit value, and a 4-byte read at 0x001C returns bits 63:32 of it. Both appear in bus_rdata[31:0], with the upper word zero.
- R7: A write of value N to offset 0x0020 stores N, which reads back unchanged. If N < NUM_VEC, only irq_pend[N] is set, and irq_strobe is high for exactly the next cycle with irq_num = N. If N >= NUM_VEC, no bit is set and no strobe is given.
- R8: Once set, a pending bit stays set until reset or soft reset.
- R9: A write to offset 0x0300 with bit 0 set clears, at that edge, both test registers, the staging register, the interrupt-test register and all pending bits. A write there with bit 0 clear changes nothing. Offset 0x0300 reads as zero.
- R10: Reads of any other offset in the window return zero, and writes to them change nothing. An 8-byte write at 0x001C is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset within the window (ADDR_W = log2 WIN_BYTES) |
| bus_we | input | 1 | Write enable for this cycle |
| bus_dw | input | 1 | Access size: 1 = 8 bytes, 0 = 4 bytes |
| bus_wdata | input | 64 | Write data, 4-byte accesses use bits 31:0 |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq_pend | output | NUM_VEC | Pending bit per interrupt vector |
| irq_strobe | output | 1 | One-cycle pulse when a vector is raised |
| irq_num | output | VEC_W | Number of the vector raised with irq_strobe |

## Verification
The bench builds the block with its defaults: NUM_VEC = 256 and a 0x2000-byte window. This makes vector 255, the top pending bit, reachable, and it makes a write of 300 a genuine out-of-range vector number. The window is wide enough to probe unmapped offsets both near the registers and at the far end of the window. The chosen data values make the doubling carry out of bit 31 and out of bit 63. The split-write cases cover a lower half that is staged but not yet committed, an upper half written on its own, and the staging register being cleared by a soft reset.

// File: rtl/diag_pkg.sv
// Shared constants and types for the diagnostic register bank.
// Assumes byte offsets are compared on the full window address width.
package diag_pkg;

    localparam int unsigned OFF_T32    = 32'h0010;
    localparam int unsigned OFF_T64_LO = 32'h0018;
    localparam int unsigned OFF_T64_HI = 32'h001C;
    localparam int unsigned OFF_IRQ    = 32'h0020;
    localparam int unsigned OFF_CTRL   = 32'h0300;

    typedef enum logic [2:0] {
        RGN_NONE   = 3'd0,
        RGN_T32    = 3'd1,
        RGN_T64_LO = 3'd2,
        RGN_T64_HI = 3'd3,
        RGN_IRQ    = 3'd4,
        RGN_CTRL   = 3'd5
    } region_e;

endpackage

// File: rtl/diag_decode.sv
// Address decoder: maps a byte offset to the register region it selects.
// Assumes the offset is already confined to the window; anything else is RGN_NONE.
module diag_decode
    import diag_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    // Compare the offset against each mapped register.
    always_comb begin
        region = RGN_NONE;
        if (addr == ADDR_W'(OFF_T32))         region = RGN_T32;
        else if (addr == ADDR_W'(OFF_T64_LO)) region = RGN_T64_LO;
        else if (addr == ADDR_W'(OFF_T64_HI)) region = RGN_T64_HI;
        else if (addr == ADDR_W'(OFF_IRQ))    region = RGN_IRQ;
        else if (addr == ADDR_W'(OFF_CTRL))   region = RGN_CTRL;
    end

endmodule

// File: rtl/diag_split64.sv
// 64-bit register with an ordered two-half write path.
// A lower-half write is staged; an upper-half write commits {upper, staged}.
// Assumes at most one of wr_full, wr_lo, wr_hi is high per cycle.
module diag_split64 #(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_full,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);

    logic [HALF_W-1:0] stage_q;

    // Hold the lower half until its upper half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  stage_q <= '0;
        else if (wr_lo)     stage_q <= wdata[HALF_W-1:0];
    end

    // Update the full value on an 8-byte write or an upper-half commit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  value <= '0;
        else if (wr_full)   value <= wdata;
        else if (wr_hi)     value <= {wdata[HALF_W-1:0], stage_q};
    end

endmodule

// File: rtl/diag_irq_gen.sv
// Interrupt-test generator: a written number N raises vector N alone.
// Keeps one sticky pending bit per vector and a one-cycle strobe with the number.
// Assumes clr and fire_req never coincide (they come from different offsets).
module diag_irq_gen #(
    parameter int NUM_VEC = 256,
    localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               fire_req,
    input  logic [31:0]        fire_val,
    output logic [NUM_VEC-1:0] pend,
    output logic               strobe,
    output logic [VEC_W-1:0]   num
);

    logic             fire_ok;
    logic [VEC_W-1:0] fire_idx;

    // Accept only numbers that name an existing vector.
    always_comb begin
        fire_ok  = fire_req && (fire_val < 32'(NUM_VEC));
        fire_idx = fire_val[VEC_W-1:0];
    end

    // One sticky pending bit per vector.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                          pend[g] <= 1'b0;
            else if (fire_ok && fire_idx == VEC_W'(g))  pend[g] <= 1'b1;
        end
    end

    // Single-cycle strobe carrying the raised vector number.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            strobe <= 1'b0;
            num    <= '0;
        end else begin
            strobe <= fire_ok;
            if (fire_ok) num <= fire_idx;
        end
    end

endmodule

// File: rtl/diag_regbank.sv
// Diagnostic register bank: doubling scratch registers (32 and 64 bit),
// an interrupt-test register and a control register with a soft-reset bit.
// Assumes a synchronous active-low reset and combinational reads from bus_addr.
module diag_regbank
    import diag_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int WIN_BYTES = 8192,
    localparam int ADDR_W   = $clog2(WIN_BYTES),
    localparam int VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic               bus_dw,
    input  logic [63:0]        bus_wdata,
    output logic [63:0]        bus_rdata,
    output logic [NUM_VEC-1:0] irq_pend,
    output logic               irq_strobe,
    output logic [VEC_W-1:0]   irq_num
);

    region_e     region;
    logic        soft_clr;
    logic        wr_t32;
    logic        wr_full;
    logic        wr_lo;
    logic        wr_hi;
    logic        wr_irq;
    logic [31:0] t32_q;
    logic [31:0] irq_last_q;
    logic [63:0] t64_val;
    logic [31:0] dbl32;
    logic [63:0] dbl64;

    diag_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    // Write strobes per region; an 8-byte write at the upper half is dropped.
    always_comb begin
        soft_clr = bus_we && (region == RGN_CTRL) && bus_wdata[0];
        wr_t32   = bus_we && (region == RGN_T32);
        wr_full  = bus_we && (region == RGN_T64_LO) && bus_dw;
        wr_lo    = bus_we && (region == RGN_T64_LO) && !bus_dw;
        wr_hi    = bus_we && (region == RGN_T64_HI) && !bus_dw;
        wr_irq   = bus_we && (region == RGN_IRQ);
    end

    // 32-bit scratch register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) t32_q <= '0;
        else if (wr_t32)        t32_q <= bus_wdata[31:0];
    end

    // Last value written to the interrupt-test register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) irq_last_q <= '0;
        else if (wr_irq)        irq_last_q <= bus_wdata[31:0];
    end

    diag_split64 #(.DATA_W(64)) u_t64 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clr),
        .wr_full (wr_full),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (bus_wdata),
        .value   (t64_val)
    );

    diag_irq_gen #(.NUM_VEC(NUM_VEC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_clr),
        .fire_req (wr_irq),
        .fire_val (bus_wdata[31:0]),
        .pend     (irq_pend),
        .strobe   (irq_strobe),
        .num      (irq_num)
    );

    // Doubled images of the scratch registers, wrapping at their widths.
    always_comb begin
        dbl32 = {t32_q[30:0], 1'b0};
        dbl64 = {t64_val[62:0], 1'b0};
    end

    // Read mux: unmapped and write-only offsets return zero.
    always_comb begin
        unique case (region)
            RGN_T32:    bus_rdata = {32'h0, dbl32};
            RGN_T64_LO: bus_rdata = bus_dw ? dbl64 : {32'h0, dbl64[31:0]};
            RGN_T64_HI: bus_rdata = {32'h0, dbl64[63:32]};
            RGN_IRQ:    bus_rdata = {32'h0, irq_last_q};
            default:    bus_rdata = 64'h0;
        endcase
    end

endmodule

// File: rtl/diag_regbank_chk.sv
// Property checker for diag_regbank, attached with bind below.
// Observes ports only; assumes synchronous active-low reset.
module diag_regbank_chk
    import diag_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int WIN_BYTES = 8192,
    localparam int ADDR_W   = $clog2(WIN_BYTES),
    localparam int VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic               bus_dw,
    input logic [63:0]        bus_wdata,
    input logic [63:0]        bus_rdata,
    input logic [NUM_VEC-1:0] irq_pend,
    input logic               irq_strobe,
    input logic [VEC_W-1:0]   irq_num
);

    logic irq_wr_ok;
    logic irq_wr_any;
    logic ctrl_clr;
    logic unmapped;

    // Bus events seen from the checker's side.
    always_comb begin
        irq_wr_any = bus_we && (bus_addr == ADDR_W'(OFF_IRQ));
        irq_wr_ok  = irq_wr_any && (bus_wdata[31:0] < 32'(NUM_VEC));
        ctrl_clr   = bus_we && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[0];
        unmapped   = (bus_addr != ADDR_W'(OFF_T32)) && (bus_addr != ADDR_W'(OFF_T64_LO)) &&
                     (bus_addr != ADDR_W'(OFF_T64_HI)) && (bus_addr != ADDR_W'(OFF_IRQ));
    end

    AST_IRQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_wr_ok)) |-> (irq_strobe && irq_pend[irq_num] &&
                                                 irq_num == $past(bus_wdata[VEC_W-1:0]))); // R7

    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> ($past(rst_n) && $past(irq_wr_ok))); // R7

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctrl_clr)) |-> ((irq_pend & $past(irq_pend)) == $past(irq_pend))); // R8

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl_clr)) |-> (irq_pend == '0 && !irq_strobe)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == 64'h0)); // R10

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_dw) |-> (bus_rdata[63:32] == 32'h0)); // R6

endmodule

bind diag_regbank diag_regbank_chk #(.NUM_VEC(NUM_VEC), .WIN_BYTES(WIN_BYTES)) u_chk (.*);

// File: tb/sim_diag_regbank.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor compares at negedge.
module sim_diag_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 256;
    localparam int AW = 13;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic          bus_dw = 1'b0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic [NV-1:0] irq_pend;
    logic          irq_strobe;
    logic [VW-1:0] irq_num;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic mon_valid = 1'b0;

    // Bench model of the requirements.
    logic [31:0]   m32 = '0;
    logic [63:0]   m64 = '0;
    logic [31:0]   mstage = '0;
    logic [NV-1:0] mpend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diag_regbank #(.NUM_VEC(NV), .WIN_BYTES(8192)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_dw     (bus_dw),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_pend   (irq_pend),
        .irq_strobe (irq_strobe),
        .irq_num    (irq_num)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_pend(input string tag);
        n_chk++;
        if (irq_pend !== mpend) begin
            n_fail++;
            $display("FAIL %s: pending actual %h expected %h", tag, irq_pend, mpend);
        end
    endtask

    // Driver: one write, committed at the second edge.
    task automatic put_word(input logic [AW-1:0] a, input bit dw, input logic [63:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_dw = dw; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    // Driver: one read, expected value pushed to the scoreboard.
    task automatic get_word(input logic [AW-1:0] a, input bit dw, input logic [63:0] e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0; bus_dw = dw;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        mon_valid = 1'b1;
        @(posedge clk); #1;
        mon_valid = 1'b0;
    endtask

    // Monitor: compare read data against the queued expectation.
    always @(negedge clk) begin
        if (mon_valid && exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        get_word(13'h010, 1'b0, 64'h0, "R1 t32");
        get_word(13'h018, 1'b1, 64'h0, "R1 t64");
        get_word(13'h020, 1'b0, 64'h0, "R1 irq");
        chk_pend("R1 pend");
        chk(irq_strobe === 1'b0, "R1 strobe", {63'h0, irq_strobe}, 64'h0);

        // R2: 32-bit doubling and wrap
        m32 = 32'h1234_5678;
        put_word(13'h010, 1'b0, {32'hFFFF_FFFF, m32});
        get_word(13'h010, 1'b0, {32'h0, m32 * 32'd2}, "R2 double");
        m32 = 32'h8000_0001;
        put_word(13'h010, 1'b0, {32'h0, m32});
        get_word(13'h010, 1'b0, 64'h0000_0000_0000_0002, "R2 wrap");

        // R3: 64-bit full write and wrap
        m64 = 64'h0123_4567_89AB_CDEF;
        put_word(13'h018, 1'b1, m64);
        get_word(13'h018, 1'b1, m64 * 64'd2, "R3 double");
        m64 = 64'h8000_0000_0000_0003;
        put_word(13'h018, 1'b1, m64);
        get_word(13'h018, 1'b1, 64'h6, "R3 wrap");

        // R4: staged lower half does not show until the upper half
        mstage = 32'h1111_1111;
        put_word(13'h018, 1'b0, {32'hDEAD_BEEF, mstage});
        get_word(13'h018, 1'b1, m64 * 64'd2, "R4 staged");
        m64 = {32'h2222_2222, mstage};
        put_word(13'h01C, 1'b0, {32'h0, 32'h2222_2222});
        get_word(13'h018, 1'b1, 64'h4444_4444_2222_2222, "R4 commit");

        // R6: 4-byte reads of each half
        get_word(13'h018, 1'b0, 64'h0000_0000_2222_2222, "R6 low half");
        get_word(13'h01C, 1'b0, 64'h0000_0000_4444_4444, "R6 high half");

        // R5: upper half alone reuses staged lower
        m64 = {32'h0000_0001, mstage};
        put_word(13'h01C, 1'b0, 64'h1);
        get_word(13'h018, 1'b1, m64 * 64'd2, "R5 upper only");

        // R7: single vector per written number
        put_word(13'h020, 1'b0, 64'd5);
        mpend[5] = 1'b1;
        chk(irq_strobe === 1'b1 && irq_num === 8'd5, "R7 strobe 5", {55'h0, irq_strobe, irq_num}, {55'h0, 1'b1, 8'd5});
        chk_pend("R7 pend 5");
        @(posedge clk); #1;
        chk(irq_strobe === 1'b0, "R7 strobe one cycle", {63'h0, irq_strobe}, 64'h0);
        get_word(13'h020, 1'b0, 64'd5, "R7 readback");
        put_word(13'h020, 1'b0, 64'd3);
        mpend[3] = 1'b1;
        chk_pend("R7 value 3 one bit");
        put_word(13'h020, 1'b0, 64'd255);
        mpend[255] = 1'b1;
        chk(irq_strobe === 1'b1 && irq_num === 8'd255, "R7 strobe 255", {55'h0, irq_strobe, irq_num}, {55'h0, 1'b1, 8'd255});
        chk_pend("R7 pend 255");
        put_word(13'h020, 1'b0, 64'd300);
        chk(irq_strobe === 1'b0, "R7 out of range no strobe", {63'h0, irq_strobe}, 64'h0);
        chk_pend("R7 out of range no pend");
        get_word(13'h020, 1'b0, 64'd300, "R7 out of range readback");

        // R10: unmapped offsets and misaligned 8-byte write
        put_word(13'h040, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        get_word(13'h040, 1'b0, 64'h0, "R10 unmapped read");
        get_word(13'h1FF8, 1'b1, 64'h0, "R10 window end");
        put_word(13'h01C, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA);
        get_word(13'h018, 1'b1, m64 * 64'd2, "R10 8-byte at upper ignored");
        get_word(13'h010, 1'b0, 64'h2, "R10 t32 untouched");

        // R8: pending bits held across unrelated writes
        chk_pend("R8 sticky");

        // R9: control with bit 0 clear is inert, set clears
        put_word(13'h300, 1'b0, 64'hFFFF_FFFE);
        get_word(13'h010, 1'b0, 64'h2, "R9 bit0 clear t32");
        chk_pend("R9 bit0 clear pend");
        get_word(13'h300, 1'b0, 64'h0, "R9 control reads zero");
        mstage = 32'h7777_7777;
        put_word(13'h018, 1'b0, {32'h0, mstage});
        put_word(13'h300, 1'b0, 64'h1);
        mpend = '0; m32 = '0; m64 = '0; mstage = '0;
        chk_pend("R9 pend cleared");
        get_word(13'h010, 1'b0, 64'h0, "R9 t32 cleared");
        get_word(13'h018, 1'b1, 64'h0, "R9 t64 cleared");
        get_word(13'h020, 1'b0, 64'h0, "R9 irq reg cleared");
        put_word(13'h01C, 1'b0, 64'h5);
        get_word(13'h018, 1'b1, 64'h0000_000A_0000_0000, "R9 staging cleared");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule